// File: doc/BRIEF.md
# Strobed Output Handshake Port

This block provides two byte-wide output ports, A and B, each able to run a strobed output handshake with an external peripheral. The CPU side has a single active-low write strobe `wr_n`, a two-bit address and a write-data bus. Address 0 selects port A, address 1 selects port B, address 2 is the handshake port C (not writable as data), and address 3 is the control register. A control byte with bit 7 set is a mode word and configures the ports. A control byte with bit 7 clear is a single-bit set/reset command aimed at one port C bit.

When a port is configured for strobed output, the end of a CPU write (the rising edge of `wr_n`) latches the data and drives that port's active-low buffer-full flag. The peripheral answers with an active-low acknowledge. While the acknowledge is low, buffer-full returns high. On the rising edge of the acknowledge, an interrupt flip-flop is set, and that flip-flop is cleared by the start of the next CPU write to the port. The interrupt request appears on port C only while the port's enable bit, set through a set/reset command, is 1.

All inputs are sampled synchronously on `clk`. Every edge is detected against the value seen in the previous cycle, and its effect is visible one cycle after the edge is sampled.

Top module: `strobed_out_port`

## Requirements
- R1: After reset `pa_out` and `pb_out` are 0, neither port is configured, both enables are 0, and `pc_out` is 8'h82: bits 7 and 1 high, all others low.
- R2: A write to address 3 with data bit 7 = 1 is a mode word. Port A handshakes only when bits 6:5 = 01 and bit 4 = 0. Port B handshakes only when bit 2 = 1 and bit 1 = 0. The mode word returns both buffer-full flags high and clears both interrupt flip-flops and both enables.
- R3: A write to address 0 or 1 loads `pa_out` or `pb_out` at the rising edge of `wr_n`, and the value holds until the next write to the same address. A write to address 2 changes no output.
- R4: A write to a configured port drives its buffer-full flag low one cycle after the rising edge of `wr_n` is sampled.
- R5: A configured port's buffer-full flag returns high in the cycle after its acknowledge is sampled low. If a write ends in that same cycle, the write wins.
- R6: A configured port's interrupt flip-flop is set on the rising edge of its acknowledge and cleared on the falling edge of `wr_n` addressed to that port. If both occur in the same cycle, the set wins.
- R7: A set/reset command (bit 7 = 0, bits 3:1 = port C bit index, bit 0 = new value) to bit 6 writes port A's enable, and to bit 2 writes port B's enable. The visible request is the flip-flop ANDed with its enable, so clearing the enable masks the request without losing it.
- R8: `pc_out` bit 7 is port A buffer-full, bit 3 is port A request, bit 1 is port B buffer-full and bit 0 is port B request. Bits 6 and 2 carry the acknowledge inputs and read as 0.
- R9: A set/reset command to bit 4 or 5 sets a general-purpose latch. That latch drives `pc_out[5:4]` while the last mode word had bit 3 = 0, and those bits read 0 when it had bit 3 = 1. A set/reset command to bits 7, 3, 1 or 0 changes nothing.
- R10: On a port that is not configured for strobed output, writes still load its data, but acknowledges and writes leave its buffer-full and request bits idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | CPU write strobe, active low |
| addr | input | 2 | 0 port A, 1 port B, 2 port C, 3 control |
| wdata | input | DW | CPU write data |
| ack_a_n | input | 1 | Port A acknowledge from peripheral, active low |
| ack_b_n | input | 1 | Port B acknowledge from peripheral, active low |
| pa_out | output | DW | Port A data latch |
| pb_out | output | DW | Port B data latch |
| pc_out | output | 8 | Port C handshake and general-purpose bits |

## Verification
Directed sequences walk one full write/acknowledge round on port A, toggle the enable to show masking without loss, and exercise both same-cycle collisions: a write ending while acknowledge is low, and an acknowledge rising in the same cycle that a write starts. A seeded random mix of data writes, acknowledges, arbitrary mode words and set/reset commands to all eight bit indices then separates the configured ports from the unconfigured ones and the direction of bits 5:4. After every operation it also confirms that a command on one port never disturbs the other.

// File: rtl/spo_pkg.sv
package spo_pkg;

  typedef enum logic [1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } sel_e;

  typedef struct packed {
    logic act_a;   // port A strobed output
    logic act_b;   // port B strobed output
    logic c45_in;  // port C bits 5:4 are inputs
  } mode_t;

  localparam logic [2:0] BIT_INTE_A = 3'd6;
  localparam logic [2:0] BIT_INTE_B = 3'd2;
  localparam logic [2:0] BIT_GP0    = 3'd4;
  localparam logic [2:0] BIT_GP1    = 3'd5;

  function automatic mode_t decode_mode(input logic [7:0] w);
    mode_t m;
    m.act_a  = (w[6:5] == 2'b01) && !w[4];
    m.act_b  = w[2] && !w[1];
    m.c45_in = w[3];
    return m;
  endfunction

  function automatic logic [2:0] bsr_index(input logic [7:0] w);
    return w[3:1];
  endfunction

endpackage

// File: rtl/spo_ctrl.sv
module spo_ctrl
  import spo_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_wr,
  input  logic [7:0] cword,
  output logic       mode_load,
  output mode_t      mode,
  output logic [1:0] inte,
  output logic [1:0] gp45
);

  logic       bsr_wr;
  logic [2:0] bsr_idx;

  assign mode_load = ctrl_wr && cword[7];
  assign bsr_wr    = ctrl_wr && !cword[7];
  assign bsr_idx   = bsr_index(cword);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode <= '{act_a: 1'b0, act_b: 1'b0, c45_in: 1'b1};
      inte <= 2'b00;
      gp45 <= 2'b00;
    end else if (mode_load) begin
      mode <= decode_mode(cword);
      inte <= 2'b00;
    end else if (bsr_wr) begin
      case (bsr_idx)
        BIT_INTE_A: inte[0] <= cword[0];
        BIT_INTE_B: inte[1] <= cword[0];
        BIT_GP0:    gp45[0] <= cword[0];
        BIT_GP1:    gp45[1] <= cword[0];
        default: ;
      endcase
    end
  end

  a_r7_inte_a_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bsr_wr && bsr_idx == BIT_INTE_A) |=> (inte[0] == $past(cword[0])));
  a_r2_mode_clears_inte: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (inte == 2'b00));
  a_r9_gp_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !(bsr_wr && (bsr_idx == BIT_GP0 || bsr_idx == BIT_GP1)) |=> $stable(gp45));

endmodule

// File: rtl/spo_hsk.sv
module spo_hsk #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          active,
  input  logic          mode_load,
  input  logic          wr_rise_sel,
  input  logic          wr_fall_sel,
  input  logic [DW-1:0] wdata,
  input  logic          ack_n,
  output logic [DW-1:0] data,
  output logic          obf_n,
  output logic          intr_q
);

  logic ack_d;
  logic ack_rise;

  assign ack_rise = !ack_d && ack_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_d  <= 1'b1;
      data   <= '0;
      obf_n  <= 1'b1;
      intr_q <= 1'b0;
    end else begin
      ack_d <= ack_n;
      if (wr_rise_sel) data <= wdata;
      if (mode_load) begin
        obf_n  <= 1'b1;
        intr_q <= 1'b0;
      end else if (active) begin
        if (wr_rise_sel)  obf_n <= 1'b0;
        else if (!ack_n)  obf_n <= 1'b1;
        if (ack_rise)         intr_q <= 1'b1;
        else if (wr_fall_sel) intr_q <= 1'b0;
      end
    end
  end

  a_r4_obf_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mode_load && wr_rise_sel) |=> !obf_n);
  a_r5_ack_clears_obf: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mode_load && !ack_n && !wr_rise_sel) |=> obf_n);
  a_r6_intr_set: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mode_load && ack_rise) |=> intr_q);
  a_r6_intr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !mode_load && wr_fall_sel && !ack_rise) |=> !intr_q);
  a_r2_mode_resets: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> (obf_n && !intr_q));
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !mode_load) |=> ($stable(obf_n) && $stable(intr_q)));
  a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_rise_sel |=> $stable(data));

endmodule

// File: rtl/strobed_out_port.sv
module strobed_out_port
  import spo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic [1:0]    addr,
  input  logic [DW-1:0] wdata,
  input  logic          ack_a_n,
  input  logic          ack_b_n,
  output logic [DW-1:0] pa_out,
  output logic [DW-1:0] pb_out,
  output logic [7:0]    pc_out
);

  localparam int NPORT = 2;

  logic  wr_d;
  logic  wr_rise;
  logic  wr_fall;
  sel_e  sel;
  logic  mode_load;
  mode_t mode;
  logic [1:0] inte;
  logic [1:0] gp45;

  logic [NPORT-1:0]   act;
  logic [NPORT-1:0]   ack_n_v;
  logic [NPORT-1:0]   obf_n;
  logic [NPORT-1:0]   intr_q;
  logic [NPORT-1:0]   intr_vis;
  logic [DW-1:0]      pdata [NPORT];

  assign sel     = sel_e'(addr);
  assign wr_rise = !wr_d && wr_n;
  assign wr_fall = wr_d && !wr_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_d <= 1'b1;
    else        wr_d <= wr_n;
  end

  spo_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_wr   (wr_rise && sel == SEL_CTRL),
    .cword     (wdata[7:0]),
    .mode_load (mode_load),
    .mode      (mode),
    .inte      (inte),
    .gp45      (gp45)
  );

  assign act     = {mode.act_b, mode.act_a};
  assign ack_n_v = {ack_b_n, ack_a_n};

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    spo_hsk #(.DW(DW)) u_hsk (
      .clk         (clk),
      .rst_n       (rst_n),
      .active      (act[i]),
      .mode_load   (mode_load),
      .wr_rise_sel (wr_rise && addr == 2'(i)),
      .wr_fall_sel (wr_fall && addr == 2'(i)),
      .wdata       (wdata),
      .ack_n       (ack_n_v[i]),
      .data        (pdata[i]),
      .obf_n       (obf_n[i]),
      .intr_q      (intr_q[i])
    );
    assign intr_vis[i] = intr_q[i] && inte[i];
  end

  assign pa_out = pdata[0];
  assign pb_out = pdata[1];

  always_comb begin
    pc_out    = 8'h00;
    pc_out[7] = obf_n[0];
    pc_out[3] = intr_vis[0];
    pc_out[1] = obf_n[1];
    pc_out[0] = intr_vis[1];
    if (!mode.c45_in) pc_out[5:4] = gp45;
  end

  a_r7_mask_a: assert property (@(posedge clk) disable iff (!rst_n)
    !inte[0] |-> !pc_out[3]);
  a_r7_mask_b: assert property (@(posedge clk) disable iff (!rst_n)
    !inte[1] |-> !pc_out[0]);
  a_r8_ack_bits_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!pc_out[6] && !pc_out[2]));
  a_r9_input_dir_zero: assert property (@(posedge clk) disable iff (!rst_n)
    mode.c45_in |-> (pc_out[5:4] == 2'b00));

endmodule

// File: tb/strobed_out_port_test.sv
module strobed_out_port_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_n = 1'b1;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic       ack_a_n = 1'b1;
  logic       ack_b_n = 1'b1;
  logic [7:0] pa_out, pb_out, pc_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // bench model
  logic [7:0] m_pa = 0, m_pb = 0;
  logic [1:0] m_obf = 2'b11, m_intr = 2'b00, m_inte = 2'b00, m_act = 2'b00, m_gp = 2'b00;
  logic       m_c45in = 1'b1;

  always #4 clk = ~clk;

  strobed_out_port #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .ack_a_n(ack_a_n), .ack_b_n(ack_b_n),
    .pa_out(pa_out), .pb_out(pb_out), .pc_out(pc_out)
  );

  function automatic logic [7:0] exp_pc();
    logic [7:0] v;
    v = {m_obf[0], 1'b0, (m_c45in ? 2'b00 : m_gp), m_intr[0] & m_inte[0],
         1'b0, m_obf[1], m_intr[1] & m_inte[1]};
    return v;
  endfunction

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic chk_all(input string req);
    chk({req, " pa"}, pa_out, m_pa);
    chk({req, " pb"}, pb_out, m_pb);
    chk({req, " pc"}, pc_out, exp_pc());
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_n = 1'b0;
    if (a < 2 && m_act[a]) m_intr[a] = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    case (a)
      2'd0: begin m_pa = d; if (m_act[0]) m_obf[0] = 1'b0; end
      2'd1: begin m_pb = d; if (m_act[1]) m_obf[1] = 1'b0; end
      2'd3: begin
        if (d[7]) begin
          m_act[0] = ((d & 8'h70) == 8'h20);
          m_act[1] = ((d & 8'h06) == 8'h04);
          m_c45in = d[3];
          m_obf = 2'b11; m_intr = 2'b00; m_inte = 2'b00;
        end else begin
          case (d[3:1])
            3'd6: m_inte[0] = d[0];
            3'd2: m_inte[1] = d[0];
            3'd4: m_gp[0] = d[0];
            3'd5: m_gp[1] = d[0];
            default: ;
          endcase
        end
      end
      default: ;
    endcase
  endtask

  task automatic ack_pulse(input int p);
    @(negedge clk);
    if (p == 0) ack_a_n = 1'b0; else ack_b_n = 1'b0;
    @(negedge clk);
    if (m_act[p]) m_obf[p] = 1'b1;
    if (p == 0) ack_a_n = 1'b1; else ack_b_n = 1'b1;
    @(negedge clk);
    if (m_act[p]) m_intr[p] = 1'b1;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");

    cpu_write(2'd3, 8'hA4); chk_all("R2 mode both output");
    cpu_write(2'd0, 8'h5A); chk_all("R3 R4 write A");
    cpu_write(2'd3, 8'h0D); chk_all("R7 enable A");
    ack_pulse(0);           chk_all("R5 R6 ack A");
    chk("R8 request A on bit3", pc_out[3], 1'b1);
    cpu_write(2'd3, 8'h0C); chk_all("R7 mask A");
    cpu_write(2'd3, 8'h0D); chk_all("R7 unmask keeps flop");
    cpu_write(2'd0, 8'hC3); chk_all("R6 write clears request");
    cpu_write(2'd3, 8'h09); chk_all("R9 gp bit4 drive");
    cpu_write(2'd3, 8'h0F); chk_all("R9 bsr bit7 no effect");
    cpu_write(2'd3, 8'h01); chk_all("R9 bsr bit0 no effect");
    cpu_write(2'd2, 8'hFF); chk_all("R3 port C write ignored");
    cpu_write(2'd3, 8'hAC); chk_all("R2 R9 mode clears, bits5:4 input");
    cpu_write(2'd3, 8'h80); chk_all("R10 unconfigured");
    cpu_write(2'd1, 8'h77); chk_all("R10 write B unconfigured");
    ack_pulse(1);           chk_all("R10 ack B unconfigured");

    // R5: write ends while ack held low -> write wins, then ack clears
    cpu_write(2'd3, 8'hA4);
    cpu_write(2'd3, 8'h0D);
    @(negedge clk); ack_a_n = 1'b0;
    @(negedge clk); addr = 2'd0; wdata = 8'h11; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk); m_pa = 8'h11;
    chk("R5 write wins over low ack", pc_out[7], 1'b0);
    @(negedge clk);
    chk("R5 low ack clears after", pc_out[7], 1'b1);
    ack_a_n = 1'b1;
    @(negedge clk);
    m_obf[0] = 1'b1; m_intr[0] = 1'b1;
    chk_all("R6 ack rise after overlap");

    // R6: ack rise and write start in same cycle -> set wins
    cpu_write(2'd0, 8'h22); chk_all("R6 request cleared by write");
    @(negedge clk); ack_a_n = 1'b0;
    @(negedge clk); ack_a_n = 1'b1; addr = 2'd0; wdata = 8'h33; wr_n = 1'b0;
    @(negedge clk); wr_n = 1'b1;
    @(negedge clk);
    m_pa = 8'h33; m_obf[0] = 1'b0; m_intr[0] = 1'b1;
    chk_all("R6 set wins over clear");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int op;
      logic [7:0] d;
      op = int'($urandom_range(0, 9));
      d  = 8'($urandom);
      case (op)
        0, 1: begin cpu_write(2'd0, d); chk_all("R3 R4 rand A"); end
        2, 3: begin cpu_write(2'd1, d); chk_all("R3 R4 rand B"); end
        4:    begin cpu_write(2'd2, d); chk_all("R3 rand C"); end
        5:    begin ack_pulse(0); chk_all("R5 R6 rand ack A"); end
        6:    begin ack_pulse(1); chk_all("R5 R6 rand ack B"); end
        7:    begin cpu_write(2'd3, {1'b0, d[6:0]}); chk_all("R7 R9 rand bsr"); end
        8:    begin cpu_write(2'd3, {1'b1, d[6:0]}); chk_all("R2 R10 rand mode"); end
        default: begin
          cpu_write(2'd3, (d[0] ? 8'hAC : 8'hA4)); chk_all("R2 rand both out");
        end
      endcase
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule